// File: doc/BRIEF.md
# Cycle-Steal Multi-Channel DMA Engine

This block moves single data units between a fixed peripheral register address and a stepping memory pointer. It shares one data bus with a processor. A channel is armed when its request line rises. The engine raises a bus request, and each time the processor grants the bus the engine takes one read cycle and one write cycle for a single channel. The processor loses only those two cycles, then gets the bus back.

Four channels are provided by default. Each channel has its own mode, unit counter, memory pointer, peripheral address and, for repeat operation, shadow copies of the counter and pointer. When several channels are armed at once, the lowest-numbered channel goes first. A channel that finishes its count raises a one-cycle done pulse. In single mode it also disarms itself. In repeat mode it reloads its counter and pointer and stays live.

Top module: `csdma_top`

## Requirements
- R1: While reset is asserted, and until the first request is latched, `bus_req`, `bus_rd`, `bus_wr` and `done` are all 0.
- R2: A channel is armed only by a 0-to-1 transition of its `dma_req` bit. Holding the bit high moves exactly one unit.
- R3: A request to a channel whose enable bit (mode bit 0) is 0 is ignored: no bus cycle and no `bus_req`.
- R4: `bus_req` is 1 while any channel is armed. No read or write cycle starts unless `bus_gnt` was 1 in the cycle before the read.
- R5: Each unit is one read cycle (`bus_rd`=1), immediately followed by one write cycle (`bus_wr`=1) on the next cycle. The two never overlap.
- R6: When mode bit 2 is 0, the read goes to the peripheral address and the write goes to the memory pointer. When mode bit 2 is 1, the two are swapped.
- R7: When mode bit 1 is 1, the unit is a 16-bit word. When it is 0, the unit is a byte: only `bus_rdata[7:0]` is kept and the written data is zero-extended. `bus_word` shows the unit size during both cycles.
- R8: Channels armed at the same time are served one unit per grant, lowest channel number first.
- R9: After each unit, the memory pointer advances by 2 (word) or by 1 (byte) if mode bit 3 is 1. Otherwise it stays the same. The peripheral address never changes.
- R10: Each unit decrements the counter. When the unit that brings it to 0 completes, `done[ch]` is 1 for one cycle, starting the cycle after the write. In single mode (mode bit 4 = 0), the enable bit is then cleared.
- R11: In repeat mode (mode bit 4 = 1), the unit that brings the counter to 0 reloads the counter and the memory pointer from their shadow registers in the same cycle. The channel stays enabled and `done` still pulses.
- R12: Configuration writes use `cfg_sel`: 0 = mode, 1 = counter, 2 = memory pointer, 3 = peripheral address, 4 = counter shadow, 5 = pointer shadow. The target channel is selected by `cfg_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 3 | Register selected within the channel |
| cfg_wdata | input | 16 | Configuration write data |
| dma_req | input | 4 | Per-channel transfer request lines |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_word | output | 1 | 1 = word unit, 0 = byte unit |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| done | output | 4 | Per-channel terminal-count pulse |

## Verification
The bench builds the block with its default parameters: four channels and 16-bit address, count and data paths. With four channels, all three priority positions are reachable, including a simultaneous request on channels 0, 1 and 3. The 16-bit data path lets byte zero-extension and full-word moves be told apart by value. Small counts of 1 to 3 units bring the terminal case, the repeat reload and the disarm after completion within a few cycles of each start.

// File: rtl/csdma_pkg.sv
package csdma_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} dma_st_e;

  localparam int MODE_W  = 5;
  localparam int MB_EN   = 0;
  localparam int MB_WORD = 1;
  localparam int MB_DIR  = 2;
  localparam int MB_INC  = 3;
  localparam int MB_RPT  = 4;

  localparam logic [2:0] SEL_MODE   = 3'd0;
  localparam logic [2:0] SEL_CNT    = 3'd1;
  localparam logic [2:0] SEL_MEM    = 3'd2;
  localparam logic [2:0] SEL_PER    = 3'd3;
  localparam logic [2:0] SEL_CNT_RL = 3'd4;
  localparam logic [2:0] SEL_MEM_RL = 3'd5;
endpackage

// File: rtl/csdma_rst_sync.sv
module csdma_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/csdma_req_edge.sv
module csdma_req_edge #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] req_q, pend_q, pend_n, set_v;

  always_comb begin
    set_v  = req & ~req_q & en;
    pend_n = (pend_q & ~clr) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req;
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_edge_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(req[i]) && $past(en[i]));
  end
endmodule

// File: rtl/csdma_arb.sv
module csdma_arb #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt
);
  logic [NCH-1:0] lower_any;

  assign lower_any[0] = 1'b0;
  for (genvar i = 1; i < NCH; i++) begin : g_mask
    assign lower_any[i] = lower_any[i-1] | req[i-1];
  end
  assign gnt = req & ~lower_any;

  always_comb begin
    assert_onehot_gnt_R8: assert ($onehot0(gnt));
    assert_lowest_wins_R8: assert (gnt == (req & (~req + NCH'(1))));
  end
endmodule

// File: rtl/csdma_chan_regs.sv
module csdma_chan_regs
  import csdma_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int CFG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic              step,
  output logic [MODE_W-1:0] mode_o,
  output logic [AW-1:0]     mem_o,
  output logic [AW-1:0]     per_o,
  output logic              last_o
);
  logic [MODE_W-1:0] mode_q, mode_n;
  logic [CW-1:0]     cnt_q, cnt_n, crl_q, crl_n;
  logic [AW-1:0]     mem_q, mem_n, mrl_q, mrl_n, per_q, per_n;
  logic              upd;

  assign last_o = (cnt_q == CW'(1));
  assign upd    = step | wr_en;

  always_comb begin
    mode_n = mode_q;
    cnt_n  = cnt_q;
    crl_n  = crl_q;
    mem_n  = mem_q;
    mrl_n  = mrl_q;
    per_n  = per_q;
    if (step) begin
      if (mode_q[MB_INC]) mem_n = mem_q + (mode_q[MB_WORD] ? AW'(2) : AW'(1));
      cnt_n = cnt_q - CW'(1);
      if (last_o) begin
        if (mode_q[MB_RPT]) begin
          cnt_n = crl_q;
          mem_n = mrl_q;
        end else begin
          mode_n[MB_EN] = 1'b0;
        end
      end
    end
    if (wr_en) begin
      case (wr_sel)
        SEL_MODE:   mode_n = wr_data[MODE_W-1:0];
        SEL_CNT:    cnt_n  = wr_data[CW-1:0];
        SEL_MEM:    mem_n  = wr_data[AW-1:0];
        SEL_PER:    per_n  = wr_data[AW-1:0];
        SEL_CNT_RL: crl_n  = wr_data[CW-1:0];
        SEL_MEM_RL: mrl_n  = wr_data[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= '0;
      crl_q  <= '0;
      mem_q  <= '0;
      mrl_q  <= '0;
      per_q  <= '0;
    end else if (upd) begin
      mode_q <= mode_n;
      cnt_q  <= cnt_n;
      crl_q  <= crl_n;
      mem_q  <= mem_n;
      mrl_q  <= mrl_n;
      per_q  <= per_n;
    end
  end

  assign mode_o = mode_q;
  assign mem_o  = mem_q;
  assign per_o  = per_q;

  assert_single_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_o && !mode_q[MB_RPT] && !wr_en) |=> !mode_q[MB_EN]);
  assert_repeat_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_o && mode_q[MB_RPT] && !wr_en) |=>
      (cnt_q == $past(crl_q)) && (mem_q == $past(mrl_q)) && mode_q[MB_EN]);
  assert_per_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(per_q));
endmodule

// File: rtl/csdma_top.sv
module csdma_top
  import csdma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int DW  = 16,
  localparam int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CFG_W = (AW > CW) ? AW : CW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CHW-1:0]   cfg_ch,
  input  logic [2:0]       cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [NCH-1:0]   dma_req,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_rd,
  output logic             bus_wr,
  output logic             bus_word,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  output logic [NCH-1:0]   done
);
  logic rst_sync_n;

  csdma_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  logic [MODE_W-1:0] mode_a [NCH];
  logic [AW-1:0]     mem_a  [NCH];
  logic [AW-1:0]     per_a  [NCH];
  logic [NCH-1:0]    last_v, en_v, step_v, pend_v, win_v;

  dma_st_e           st_q, st_n;
  logic [NCH-1:0]    sel_q, sel_n, done_q, done_n;
  logic [DW-1:0]     data_q, data_n;
  logic              sel_ld, data_ld;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    csdma_chan_regs #(.AW(AW), .CW(CW), .CFG_W(CFG_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_en  (cfg_we && (cfg_ch == CHW'(i))),
      .wr_sel (cfg_sel),
      .wr_data(cfg_wdata),
      .step   (step_v[i]),
      .mode_o (mode_a[i]),
      .mem_o  (mem_a[i]),
      .per_o  (per_a[i]),
      .last_o (last_v[i])
    );
    assign en_v[i] = mode_a[i][MB_EN];
  end

  csdma_req_edge #(.NCH(NCH)) u_edge (
    .clk (clk), .rst_n(rst_sync_n), .req(dma_req),
    .en  (en_v), .clr(step_v), .pend(pend_v)
  );

  csdma_arb #(.NCH(NCH)) u_arb (.req(pend_v), .gnt(win_v));

  // selected channel view
  logic [MODE_W-1:0] s_mode;
  logic [AW-1:0]     s_mem, s_per;
  always_comb begin
    s_mode = '0;
    s_mem  = '0;
    s_per  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel_q[i]) begin
        s_mode = mode_a[i];
        s_mem  = mem_a[i];
        s_per  = per_a[i];
      end
    end
  end

  assign step_v = (st_q == ST_WR) ? sel_q : '0;

  always_comb begin
    st_n    = st_q;
    sel_n   = sel_q;
    sel_ld  = 1'b0;
    data_ld = 1'b0;
    data_n  = s_mode[MB_WORD] ? bus_rdata : {{(DW-8){1'b0}}, bus_rdata[7:0]};
    done_n  = step_v & last_v;
    case (st_q)
      ST_IDLE: if (bus_gnt && (|pend_v)) begin
        st_n   = ST_RD;
        sel_n  = win_v;
        sel_ld = 1'b1;
      end
      ST_RD: begin
        st_n    = ST_WR;
        data_ld = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      data_q <= '0;
      done_q <= '0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      if (sel_ld)  sel_q  <= sel_n;
      if (data_ld) data_q <= data_n;
    end
  end

  always_comb begin
    bus_addr = '0;
    if (st_q == ST_RD)      bus_addr = s_mode[MB_DIR] ? s_mem : s_per;
    else if (st_q == ST_WR) bus_addr = s_mode[MB_DIR] ? s_per : s_mem;
  end

  assign bus_req   = (|pend_v) || (st_q != ST_IDLE);
  assign bus_rd    = (st_q == ST_RD);
  assign bus_wr    = (st_q == ST_WR);
  assign bus_word  = (st_q != ST_IDLE) && s_mode[MB_WORD];
  assign bus_wdata = (st_q == ST_WR) ? data_q : '0;
  assign done      = done_q;

  assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rd |=> bus_wr);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_rd && bus_wr));
  assert_steal_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_rd |-> $past(bus_gnt));
  assert_done_onehot_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(done));
  assert_req_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd || bus_wr) |-> bus_req);
endmodule

// File: tb/csdma_top_bench.sv
module csdma_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_ch;
  logic [2:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic [3:0]  dma_req;
  logic        bus_req, bus_gnt, bus_rd, bus_wr, bus_word;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  done;
  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  assign bus_rdata = bus_addr ^ 16'h5A5A;

  csdma_top u_csdma_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dma_req(dma_req), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done(done)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [4:0]  mode;
    logic [15:0] mem;
    logic [15:0] per;
    logic [15:0] exp_rd;
    logic [15:0] exp_wr;
    logic [15:0] exp_data;
  } vec_t;

  // mode bits: [4] repeat, [3] step, [2] direction, [1] word, [0] enable
  localparam vec_t VEC [4] = '{
    '{2'd0, 5'b00011, 16'h2000, 16'h0100, 16'h0100, 16'h2000, 16'h5B5A},
    '{2'd1, 5'b00101, 16'h3001, 16'h0200, 16'h3001, 16'h0200, 16'h005B},
    '{2'd2, 5'b00111, 16'h4000, 16'h0300, 16'h4000, 16'h0300, 16'h1A5A},
    '{2'd3, 5'b00001, 16'h5000, 16'h0401, 16'h0401, 16'h5000, 16'h005B}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] ch, input logic [2:0] sel, input logic [15:0] val);
    cfg_we = 1'b1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [1:0] ch, input logic [4:0] mode, input logic [15:0] cnt,
                       input logic [15:0] mem, input logic [15:0] per);
    cfg(ch, 3'd1, cnt);
    cfg(ch, 3'd2, mem);
    cfg(ch, 3'd3, per);
    cfg(ch, 3'd0, {11'd0, mode});
  endtask

  task automatic pulse(input logic [3:0] mask);
    dma_req = mask;
    @(negedge clk);
    dma_req = 4'd0;
  endtask

  task automatic unit(input string tag, input logic [15:0] rd, input logic [15:0] wr,
                      input logic [15:0] data, input logic word, input logic [3:0] dn);
    int w = 0;
    while (!bus_rd && w < 20) begin @(negedge clk); w++; end
    chk({tag, " read strobe"}, bus_rd, 1'b1);
    chk({tag, " read addr"}, bus_addr, rd);
    chk({tag, " word flag rd"}, bus_word, word);
    @(negedge clk);
    chk({tag, " R5 write follows"}, {bus_wr, bus_rd}, 2'b10);
    chk({tag, " write addr"}, bus_addr, wr);
    chk({tag, " R7 write data"}, bus_wdata, data);
    @(negedge clk);
    chk({tag, " R10 done"}, done, dn);
  endtask

  task automatic quiet(input string tag, input int n);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (bus_rd || bus_wr) seen++;
    end
    chk({tag, " no bus cycle"}, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog R5: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_sel = '0; cfg_wdata = '0;
    dma_req = '0; bus_gnt = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {bus_req, bus_rd, bus_wr, done}, 7'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {bus_req, bus_rd, bus_wr, done}, 7'd0);

    // R6 R7 R10 R12: one unit per channel from the vector table
    foreach (VEC[v]) begin
      setup(VEC[v].ch, VEC[v].mode, 16'd1, VEC[v].mem, VEC[v].per);
      pulse(4'b0001 << VEC[v].ch);
      unit("R6 vector", VEC[v].exp_rd, VEC[v].exp_wr, VEC[v].exp_data,
           VEC[v].mode[1], 4'b0001 << VEC[v].ch);
      pulse(4'b0001 << VEC[v].ch);
      quiet("R10 disarmed after count", 8);
    end

    // R9 word step
    setup(2'd0, 5'b01011, 16'd3, 16'h1000, 16'h0010);
    pulse(4'b0001); unit("R9 word step 0", 16'h0010, 16'h1000, 16'h5A4A, 1'b1, 4'b0000);
    pulse(4'b0001); unit("R9 word step 1", 16'h0010, 16'h1002, 16'h5A4A, 1'b1, 4'b0000);
    pulse(4'b0001); unit("R9 word step 2", 16'h0010, 16'h1004, 16'h5A4A, 1'b1, 4'b0001);

    // R9 no step, memory to peripheral byte
    setup(2'd1, 5'b00101, 16'd2, 16'h1100, 16'h0030);
    pulse(4'b0010); unit("R9 fixed ptr 0", 16'h1100, 16'h0030, 16'h005A, 1'b0, 4'b0000);
    pulse(4'b0010); unit("R9 fixed ptr 1", 16'h1100, 16'h0030, 16'h005A, 1'b0, 4'b0010);

    // R11 repeat
    cfg(2'd2, 3'd4, 16'd2);
    cfg(2'd2, 3'd5, 16'h6000);
    setup(2'd2, 5'b11001, 16'd2, 16'h6000, 16'h0020);
    pulse(4'b0100); unit("R11 repeat 0", 16'h0020, 16'h6000, 16'h007A, 1'b0, 4'b0000);
    pulse(4'b0100); unit("R11 repeat 1", 16'h0020, 16'h6001, 16'h007A, 1'b0, 4'b0100);
    pulse(4'b0100); unit("R11 reloaded", 16'h0020, 16'h6000, 16'h007A, 1'b0, 4'b0000);

    // R4 R8 priority with the grant held off
    setup(2'd0, 5'b00001, 16'd1, 16'h7000, 16'h0040);
    setup(2'd1, 5'b00001, 16'd1, 16'h7100, 16'h0041);
    setup(2'd3, 5'b00001, 16'd1, 16'h7300, 16'h0043);
    bus_gnt = 1'b0;
    pulse(4'b1011);
    quiet("R4 no grant", 4);
    chk("R4 bus_req raised", bus_req, 1'b1);
    bus_gnt = 1'b1;
    unit("R8 first ch0", 16'h0040, 16'h7000, 16'h001A, 1'b0, 4'b0001);
    unit("R8 then ch1", 16'h0041, 16'h7100, 16'h001B, 1'b0, 4'b0010);
    unit("R8 then ch3", 16'h0043, 16'h7300, 16'h0019, 1'b0, 4'b1000);
    chk("R4 bus_req dropped", bus_req, 1'b0);

    // R2 level held high moves one unit
    setup(2'd0, 5'b00001, 16'd2, 16'h7800, 16'h0050);
    dma_req = 4'b0001;
    unit("R2 level once", 16'h0050, 16'h7800, 16'h000A, 1'b0, 4'b0000);
    quiet("R2 held level", 8);
    dma_req = 4'b0000;

    // R3 disabled channel
    setup(2'd3, 5'b00000, 16'd1, 16'h7900, 16'h0060);
    pulse(4'b1000);
    chk("R3 bus_req idle", bus_req, 1'b0);
    quiet("R3 disabled", 8);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule